// File: doc/BRIEF.md
# Linked Command Segment Fetcher

This block walks a chain of command segments kept in memory and produces one memory read address for each command word a consumer pulls. Software writes a single configuration word holding a 128-byte aligned starting pointer, the segment length in 64-bit words, a free-list number and a don't-write-back count. After that write, each pull from the consumer is answered with one read request. The returned word is passed straight back to the consumer.

Every segment reserves its highest word for a link to the next segment, so a segment of N words carries N-1 command words. When the last command word of a segment has been delivered, the block reads the link word without waiting for a pull. The link replaces the current pointer and the word offset restarts at zero. The block then offers the exhausted segment's base address, together with the configured free-list number and don't-write-back count, on a valid/ready free-request port. The free request is held in a one-entry slot. Fetching from the new segment can continue while that slot waits. Only the next link read waits for the slot to empty.

Top module: `cmdbuf_seg_fetch`

## Requirements
- R1: After reset the block is unconfigured: `pull_ready_o`, `rd_valid_o`, `cmd_valid_o` and `free_valid_o` are all low.
- R2: The configuration word is decoded as follows: bits [32:0] are byte-address bits [39:7] of the first segment, bits [45:33] are the segment size in 64-bit words, bits [48:46] are the free-list number and bits [57:49] are the don't-write-back count. A write with size of at least 2 makes `pull_ready_o` high from the next cycle.
- R3: After a configuration write with size 0 or 1, no pull is accepted and no read is issued.
- R4: Each accepted pull produces exactly one read request, at byte address segment base + 8 × word offset. The request address stays stable while `rd_valid_o` is high and `rd_ready_i` is low.
- R5: The response to a command read appears on `cmd_data_o` with `cmd_valid_o` high in the same cycle. A response that arrives while no read is outstanding produces no `cmd_valid_o`.
- R6: After size-1 command words, the block reads word size-1 of the segment on its own. Bits [39:7] of that word become the new segment pointer, the offset returns to zero, and the next command read goes to the new base.
- R7: After a link word returns, the block raises `free_valid_o` with the old segment base, the configured free-list number and the don't-write-back count. All three are held stable until `free_ready_i` is high.
- R8: A pending free request does not hold back command reads from the new segment. A free handshake and a command read handshake may complete in the same cycle.
- R9: While a free request is still pending, the block issues no link read for a further exhausted segment.
- R10: A configuration write restarts fetching at the new pointer with offset zero, even in the middle of a segment. A free request that is pending at the time of the write is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 58 | Configuration word (layout in R2) |
| pull_valid_i | input | 1 | Consumer requests the next command word |
| pull_ready_o | output | 1 | Pull accepted this cycle when both are high |
| rd_valid_o | output | 1 | Memory read request valid |
| rd_ready_i | input | 1 | Memory accepts the read request |
| rd_addr_o | output | 40 | Byte address of the 64-bit word to read |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 64 | Read data |
| cmd_valid_o | output | 1 | Command word delivered this cycle |
| cmd_data_o | output | 64 | Command word |
| free_valid_o | output | 1 | Free request valid |
| free_ready_i | input | 1 | Free request accepted |
| free_addr_o | output | 40 | Base byte address of the segment being freed |
| free_pool_o | output | 3 | Free-list number |
| free_dwb_o | output | 9 | Don't-write-back count |

## Verification
Two handshakes can land on the same clock edge: returning a finished segment through the free port, and reading a command word of the next segment. The bench holds the free port back across a segment change. It then raises `free_ready_i` in the very cycle a command read request is valid. It checks that both the freed base and the command read address are logged, and that the read data still returns correctly. A second exhaustion is also provoked while the free slot is full. The check there is that no link read appears until the slot drains, and that both segments are then freed in order.

// File: rtl/cmdbuf_fetch_pkg.sv
package cmdbuf_fetch_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_CREQ  = 3'd2,
    ST_CWAIT = 3'd3,
    ST_LREQ  = 3'd4,
    ST_LWAIT = 3'd5
  } fetch_st_e;

  localparam int MIN_SEG_WORDS = 2;

endpackage

// File: rtl/cmdbuf_cfg_reg.sv
module cmdbuf_cfg_reg #(
  parameter int PTR_W  = 33,
  parameter int SIZE_W = 13,
  parameter int POOL_W = 3,
  parameter int DWB_W  = 9,
  localparam int CFG_W = PTR_W + SIZE_W + POOL_W + DWB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CFG_W-1:0]  data_i,
  output logic [PTR_W-1:0]  new_ptr_o,
  output logic              new_ok_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [POOL_W-1:0] pool_o,
  output logic [DWB_W-1:0]  dwb_o,
  output logic              ok_o
);
  import cmdbuf_fetch_pkg::*;

  localparam int SIZE_LSB = PTR_W;
  localparam int POOL_LSB = SIZE_LSB + SIZE_W;
  localparam int DWB_LSB  = POOL_LSB + POOL_W;

  logic [SIZE_W-1:0] new_size;
  logic [SIZE_W-1:0] size_q;
  logic [POOL_W-1:0] pool_q;
  logic [DWB_W-1:0]  dwb_q;
  logic              ok_q;

  always_comb begin
    new_ptr_o = data_i[PTR_W-1:0];
    new_size  = data_i[SIZE_LSB +: SIZE_W];
    new_ok_o  = (new_size >= SIZE_W'(MIN_SEG_WORDS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      pool_q <= '0;
      dwb_q  <= '0;
      ok_q   <= 1'b0;
    end else if (wr_i) begin
      size_q <= new_size;
      pool_q <= data_i[POOL_LSB +: POOL_W];
      dwb_q  <= data_i[DWB_LSB +: DWB_W];
      ok_q   <= new_ok_o;
    end
  end

  assign size_o = size_q;
  assign pool_o = pool_q;
  assign dwb_o  = dwb_q;
  assign ok_o   = ok_q;

  // R2: a usable segment size is kept only together with a set ok flag
  p_size_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> (size_q >= SIZE_W'(MIN_SEG_WORDS)));

endmodule

// File: rtl/cmdbuf_seg_cursor.sv
module cmdbuf_seg_cursor #(
  parameter int ADDR_W     = 40,
  parameter int LINE_SHIFT = 7,
  parameter int SIZE_W     = 13,
  parameter int WORD_SHIFT = 3,
  localparam int PTR_W     = ADDR_W - LINE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic [PTR_W-1:0]  init_ptr_i,
  input  logic              step_i,
  input  logic              link_i,
  input  logic [PTR_W-1:0]  link_ptr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              last_cmd_o
);
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [SIZE_W-1:0] off_q, off_d;
  logic              upd_en;

  always_comb begin
    ptr_d  = ptr_q;
    off_d  = off_q;
    upd_en = init_i | step_i | link_i;
    if (init_i) begin
      ptr_d = init_ptr_i;
      off_d = '0;
    end else if (link_i) begin
      ptr_d = link_ptr_i;
      off_d = '0;
    end else if (step_i) begin
      off_d = off_q + SIZE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      off_q <= '0;
    end else if (upd_en) begin
      ptr_q <= ptr_d;
      off_q <= off_d;
    end
  end

  always_comb begin
    base_o     = {ptr_q, {LINE_SHIFT{1'b0}}};
    rd_addr_o  = base_o + ADDR_W'({off_q, {WORD_SHIFT{1'b0}}});
    last_cmd_o = (off_q == (size_i - SIZE_W'(2)));
  end

  // R6: the controls from the sequencer never collide
  p_one_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_i, step_i, link_i}));

  // R6: the offset never passes the link word of a usable segment
  p_offset_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i >= SIZE_W'(2)) |-> (off_q < size_i));

  // R6: after following a link, the next fetch starts at the new base
  p_link_rebase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && !init_i) |=> (rd_addr_o == base_o));

endmodule

// File: rtl/cmdbuf_free_slot.sv
module cmdbuf_free_slot #(
  parameter int ADDR_W = 40,
  parameter int POOL_W = 3,
  parameter int DWB_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [POOL_W-1:0] pool_i,
  input  logic [DWB_W-1:0]  dwb_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [POOL_W-1:0] pool_o,
  output logic [DWB_W-1:0]  dwb_o
);
  logic              full_q, full_d;
  logic [ADDR_W-1:0] addr_q;
  logic [POOL_W-1:0] pool_q;
  logic [DWB_W-1:0]  dwb_q;

  always_comb begin
    full_d = full_q;
    if (full_q && ready_i) full_d = 1'b0;
    if (load_i)            full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pool_q <= '0;
      dwb_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      pool_q <= pool_i;
      dwb_q  <= dwb_i;
    end
  end

  assign valid_o = full_q;
  assign addr_o  = addr_q;
  assign pool_o  = pool_q;
  assign dwb_o   = dwb_q;

  // R9: a new free request only ever lands in an empty slot
  p_load_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !full_q);

  // R7: an unaccepted free request keeps its contents
  p_free_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !ready_i) |=> (full_q && $stable(addr_q) && $stable(pool_q) && $stable(dwb_q)));

endmodule

// File: rtl/cmdbuf_fetch_fsm.sv
module cmdbuf_fetch_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr_i,
  input  logic cfg_new_ok_i,
  input  logic pull_valid_i,
  output logic pull_ready_o,
  output logic rd_valid_o,
  input  logic rd_ready_i,
  input  logic rsp_valid_i,
  input  logic last_cmd_i,
  input  logic free_busy_i,
  output logic step_o,
  output logic link_o,
  output logic cmd_valid_o
);
  import cmdbuf_fetch_pkg::*;

  fetch_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (cfg_wr_i) begin
      st_d = cfg_new_ok_i ? ST_IDLE : ST_OFF;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (pull_valid_i) st_d = ST_CREQ;
        ST_CREQ:  if (rd_ready_i) st_d = ST_CWAIT;
        ST_CWAIT: if (rsp_valid_i) st_d = last_cmd_i ? ST_LREQ : ST_IDLE;
        ST_LREQ:  if (rd_ready_i && !free_busy_i) st_d = ST_LWAIT;
        ST_LWAIT: if (rsp_valid_i) st_d = ST_IDLE;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OFF;
    end else begin
      st_q <= st_d;
    end
  end

  always_comb begin
    pull_ready_o = (st_q == ST_IDLE) && !cfg_wr_i;
    rd_valid_o   = (st_q == ST_CREQ) || ((st_q == ST_LREQ) && !free_busy_i);
    step_o       = (st_q == ST_CWAIT) && rsp_valid_i && !cfg_wr_i;
    link_o       = (st_q == ST_LWAIT) && rsp_valid_i && !cfg_wr_i;
    cmd_valid_o  = step_o;
  end

  // R5: a delivered command word is a single-cycle event
  p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R9: no link read is offered while the free slot is occupied
  p_link_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_busy_i && !pull_ready_o && rd_valid_o) |-> (st_q == ST_CREQ));

endmodule

// File: rtl/cmdbuf_seg_fetch.sv
module cmdbuf_seg_fetch #(
  parameter int ADDR_W     = 40,
  parameter int LINE_SHIFT = 7,
  parameter int SIZE_W     = 13,
  parameter int POOL_W     = 3,
  parameter int DWB_W      = 9,
  parameter int DATA_W     = 64,
  localparam int PTR_W     = ADDR_W - LINE_SHIFT,
  localparam int CFG_W     = PTR_W + SIZE_W + POOL_W + DWB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              pull_valid_i,
  output logic              pull_ready_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              free_valid_o,
  input  logic              free_ready_i,
  output logic [ADDR_W-1:0] free_addr_o,
  output logic [POOL_W-1:0] free_pool_o,
  output logic [DWB_W-1:0]  free_dwb_o
);
  logic [PTR_W-1:0]  cfg_new_ptr;
  logic              cfg_new_ok;
  logic [SIZE_W-1:0] cfg_size;
  logic [POOL_W-1:0] cfg_pool;
  logic [DWB_W-1:0]  cfg_dwb;
  logic              cfg_ok;
  logic              seq_step;
  logic              seq_link;
  logic              seg_last;
  logic [ADDR_W-1:0] seg_base;

  cmdbuf_cfg_reg #(
    .PTR_W (PTR_W),
    .SIZE_W(SIZE_W),
    .POOL_W(POOL_W),
    .DWB_W (DWB_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cfg_wr_i),
    .data_i   (cfg_data_i),
    .new_ptr_o(cfg_new_ptr),
    .new_ok_o (cfg_new_ok),
    .size_o   (cfg_size),
    .pool_o   (cfg_pool),
    .dwb_o    (cfg_dwb),
    .ok_o     (cfg_ok)
  );

  cmdbuf_seg_cursor #(
    .ADDR_W    (ADDR_W),
    .LINE_SHIFT(LINE_SHIFT),
    .SIZE_W    (SIZE_W)
  ) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (cfg_wr_i),
    .init_ptr_i(cfg_new_ptr),
    .step_i    (seq_step),
    .link_i    (seq_link),
    .link_ptr_i(rsp_data_i[ADDR_W-1:LINE_SHIFT]),
    .size_i    (cfg_size),
    .base_o    (seg_base),
    .rd_addr_o (rd_addr_o),
    .last_cmd_o(seg_last)
  );

  cmdbuf_fetch_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_new_ok_i(cfg_new_ok),
    .pull_valid_i(pull_valid_i),
    .pull_ready_o(pull_ready_o),
    .rd_valid_o  (rd_valid_o),
    .rd_ready_i  (rd_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .last_cmd_i  (seg_last),
    .free_busy_i (free_valid_o),
    .step_o      (seq_step),
    .link_o      (seq_link),
    .cmd_valid_o (cmd_valid_o)
  );

  cmdbuf_free_slot #(
    .ADDR_W(ADDR_W),
    .POOL_W(POOL_W),
    .DWB_W (DWB_W)
  ) u_free (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (seq_link),
    .addr_i (seg_base),
    .pool_i (cfg_pool),
    .dwb_i  (cfg_dwb),
    .valid_o(free_valid_o),
    .ready_i(free_ready_i),
    .addr_o (free_addr_o),
    .pool_o (free_pool_o),
    .dwb_o  (free_dwb_o)
  );

  assign cmd_data_o = rsp_data_i;

  // R3: an unusable configuration keeps both the pull and read sides quiet
  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> (!rd_valid_o && !pull_ready_o));

  // R4: a stalled read request keeps its address
  p_rd_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !cfg_wr_i) |=> (rd_valid_o && $stable(rd_addr_o)));

  // R4: every read address is 64-bit word aligned
  p_rd_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_addr_o[2:0] == 3'b000));

endmodule

// File: tb/cmdbuf_seg_fetch_bench.sv
module cmdbuf_seg_fetch_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [57:0] cfg_data;
  logic        pull_valid;
  logic        pull_ready_o;
  logic        rd_valid_o;
  logic        rd_ready;
  logic [39:0] rd_addr_o;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        cmd_valid_o;
  logic [63:0] cmd_data_o;
  logic        free_valid_o;
  logic        free_ready;
  logic [39:0] free_addr_o;
  logic [2:0]  free_pool_o;
  logic [8:0]  free_dwb_o;

  int n_vec;
  int n_bad;

  logic [39:0] rd_log[$];
  logic [63:0] cmd_log[$];
  logic [51:0] free_log[$];
  logic [39:0] link_map[logic [39:0]];
  bit          pend;
  logic [39:0] pend_addr;
  bit          spur;

  localparam logic [39:0] A_BASE = 40'h12_3456_7880;
  localparam logic [39:0] B_BASE = 40'h00_ABCD_E000;
  localparam logic [39:0] C_BASE = 40'h03_0000_0100;
  localparam logic [39:0] D_BASE = 40'h04_FFFF_FF80;
  localparam logic [39:0] E_BASE = 40'h05_1200_0000;
  localparam logic [39:0] F_BASE = 40'h06_0000_0080;
  localparam logic [39:0] G_BASE = 40'h07_7777_7700;
  localparam logic [39:0] H_BASE = 40'h08_0000_1000;

  cmdbuf_seg_fetch u_cmdbuf_seg_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr),
    .cfg_data_i  (cfg_data),
    .pull_valid_i(pull_valid),
    .pull_ready_o(pull_ready_o),
    .rd_valid_o  (rd_valid_o),
    .rd_ready_i  (rd_ready),
    .rd_addr_o   (rd_addr_o),
    .rsp_valid_i (rsp_valid),
    .rsp_data_i  (rsp_data),
    .cmd_valid_o (cmd_valid_o),
    .cmd_data_o  (cmd_data_o),
    .free_valid_o(free_valid_o),
    .free_ready_i(free_ready),
    .free_addr_o (free_addr_o),
    .free_pool_o (free_pool_o),
    .free_dwb_o  (free_dwb_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] mem_word(input logic [39:0] a);
    if (link_map.exists(a)) return {24'h0, link_map[a]};
    return {24'hA5C3E1, a};
  endfunction

  function automatic logic [57:0] mk_cfg(input logic [39:0] base, input logic [12:0] sz,
                                         input logic [2:0] pool, input logic [8:0] dwb);
    return {dwb, pool, sz, base[39:7]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model and monitors: drive at falling edge, sample 1 ns later
  initial begin
    pend = 1'b0;
    spur = 1'b0;
    pend_addr = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        rsp_valid = 1'b1;
        rsp_data  = mem_word(pend_addr);
        pend      = 1'b0;
      end else if (spur) begin
        rsp_valid = 1'b1;
        rsp_data  = 64'hDEAD_0000_BEEF;
        spur      = 1'b0;
      end else begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
      end
      #1;
      if (rst_n && rd_valid_o && rd_ready) begin
        rd_log.push_back(rd_addr_o);
        pend      = 1'b1;
        pend_addr = rd_addr_o;
      end
      if (rst_n && cmd_valid_o) cmd_log.push_back(cmd_data_o);
      if (rst_n && free_valid_o && free_ready)
        free_log.push_back({free_addr_o, free_pool_o, free_dwb_o});
    end
  end

  task automatic do_cfg(input logic [39:0] base, input logic [12:0] sz,
                        input logic [2:0] pool, input logic [8:0] dwb);
    @(negedge clk);
    cfg_wr   = 1'b1;
    cfg_data = mk_cfg(base, sz, pool, dwb);
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  task automatic pull_accept();
    @(negedge clk);
    pull_valid = 1'b1;
    #1;
    while (!pull_ready_o) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    pull_valid = 1'b0;
  endtask

  task automatic wait_cmd(input int n0);
    while (cmd_log.size() == n0) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic pull_word(input logic [39:0] exp_addr, input string req);
    int n0;
    n0 = cmd_log.size();
    pull_accept();
    wait_cmd(n0);
    chk({req, " read address"}, 64'(rd_log[rd_log.size()-1]), 64'(exp_addr));
    chk({req, " command data"}, cmd_log[cmd_log.size()-1], {24'hA5C3E1, exp_addr});
  endtask

  task automatic wait_free(input int n);
    while (free_log.size() < n) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk("R1 pull_ready", 64'(pull_ready_o), 64'd0);
    chk("R1 rd_valid", 64'(rd_valid_o), 64'd0);
    chk("R1 cmd_valid", 64'(cmd_valid_o), 64'd0);
    chk("R1 free_valid", 64'(free_valid_o), 64'd0);
  endtask

  task automatic t_small_size();
    int bad;
    bad = 0;
    do_cfg(A_BASE, 13'd1, 3'd0, 9'd0);
    @(negedge clk);
    pull_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      if (pull_ready_o || rd_valid_o) bad++;
      @(negedge clk);
    end
    pull_valid = 1'b0;
    chk("R3 size 1 refuses pulls", 64'(bad), 64'd0);
    do_cfg(A_BASE, 13'd0, 3'd0, 9'd0);
    @(negedge clk);
    #1;
    chk("R3 size 0 pull_ready", 64'(pull_ready_o), 64'd0);
    chk("R3 no reads issued", 64'(rd_log.size()), 64'd0);
  endtask

  task automatic t_basic();
    link_map[A_BASE + 40'd24] = B_BASE;
    do_cfg(A_BASE, 13'd4, 3'd5, 9'h1AB);
    @(negedge clk);
    #1;
    chk("R2 pull_ready after config", 64'(pull_ready_o), 64'd1);
    pull_word(A_BASE, "R2 R4 R5 word0");
    pull_word(A_BASE + 40'd8, "R4 word1");
    pull_word(A_BASE + 40'd16, "R4 word2");
    wait_free(1);
    chk("R6 link word read", 64'(rd_log[rd_log.size()-1]), 64'(A_BASE + 40'd24));
    chk("R7 free entry", 64'(free_log[0]), 64'({A_BASE, 3'd5, 9'h1AB}));
    pull_word(B_BASE, "R6 first word of new segment");
  endtask

  task automatic t_stall();
    int bad;
    int n0;
    bad = 0;
    n0 = cmd_log.size();
    @(negedge clk);
    rd_ready = 1'b0;
    pull_accept();
    for (int i = 0; i < 4; i++) begin
      #1;
      if (!rd_valid_o || rd_addr_o !== B_BASE + 40'd8) bad++;
      @(negedge clk);
    end
    rd_ready = 1'b1;
    wait_cmd(n0);
    chk("R4 stalled request held", 64'(bad), 64'd0);
    chk("R4 stalled word data", cmd_log[cmd_log.size()-1], {24'hA5C3E1, B_BASE + 40'd8});
  endtask

  task automatic t_overlap();
    int bad;
    int nf;
    int n0;
    link_map[B_BASE + 40'd24] = C_BASE;
    link_map[C_BASE + 40'd24] = D_BASE;
    link_map[D_BASE + 40'd24] = E_BASE;
    nf = free_log.size();
    @(negedge clk);
    free_ready = 1'b0;
    pull_word(B_BASE + 40'd16, "R4 word2 of B");
    while (!free_valid_o) begin
      @(negedge clk);
      #1;
    end
    chk("R7 pending free address", 64'(free_addr_o), 64'(B_BASE));
    pull_word(C_BASE, "R8 fetch while free pending");
    chk("R8 free still pending", 64'(free_valid_o), 64'd1);
    // raise free_ready in the cycle the command read is requested
    n0 = cmd_log.size();
    pull_accept();
    free_ready = 1'b1;
    #1;
    chk("R8 read valid in same cycle", 64'(rd_valid_o), 64'd1);
    @(negedge clk);
    free_ready = 1'b0;
    wait_cmd(n0);
    chk("R8 same-cycle read address", 64'(rd_log[rd_log.size()-1]), 64'(C_BASE + 40'd8));
    chk("R8 same-cycle free", 64'(free_log[nf]), 64'({B_BASE, 3'd5, 9'h1AB}));
    pull_word(C_BASE + 40'd16, "R6 last word of C");
    while (!free_valid_o) begin
      @(negedge clk);
      #1;
    end
    chk("R6 link of C read", 64'(rd_log[rd_log.size()-1]), 64'(C_BASE + 40'd24));
    pull_word(D_BASE, "R6 word0 of D");
    pull_word(D_BASE + 40'd8, "R6 word1 of D");
    pull_word(D_BASE + 40'd16, "R6 word2 of D");
    bad = 0;
    n0 = rd_log.size();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      if (rd_valid_o) bad++;
    end
    chk("R9 link read withheld", 64'(bad), 64'd0);
    chk("R9 no read logged", 64'(rd_log.size()), 64'(n0));
    chk("R9 older free still offered", 64'(free_addr_o), 64'(C_BASE));
    @(negedge clk);
    free_ready = 1'b1;
    wait_free(nf + 3);
    chk("R9 free of C", 64'(free_log[nf+1]), 64'({C_BASE, 3'd5, 9'h1AB}));
    chk("R9 link of D after drain", 64'(rd_log[rd_log.size()-1]), 64'(D_BASE + 40'd24));
    chk("R9 free of D", 64'(free_log[nf+2]), 64'({D_BASE, 3'd5, 9'h1AB}));
  endtask

  task automatic t_spurious();
    int n0;
    n0 = cmd_log.size();
    @(negedge clk);
    spur = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 stray response ignored", 64'(cmd_log.size()), 64'(n0));
    chk("R5 still ready", 64'(pull_ready_o), 64'd1);
  endtask

  task automatic t_recfg();
    int nf;
    link_map[F_BASE + 40'd8] = G_BASE;
    pull_word(E_BASE, "R10 word0 of E");
    do_cfg(F_BASE, 13'd2, 3'd2, 9'h005);
    @(negedge clk);
    free_ready = 1'b0;
    nf = free_log.size();
    pull_word(F_BASE, "R10 restart at new pointer");
    while (!free_valid_o) begin
      @(negedge clk);
      #1;
    end
    chk("R6 size 2 link read", 64'(rd_log[rd_log.size()-1]), 64'(F_BASE + 40'd8));
    do_cfg(H_BASE, 13'd3, 3'd7, 9'h011);
    @(negedge clk);
    #1;
    chk("R10 free kept valid", 64'(free_valid_o), 64'd1);
    chk("R10 free kept fields", 64'({free_addr_o, free_pool_o, free_dwb_o}),
        64'({F_BASE, 3'd2, 9'h005}));
    pull_word(H_BASE, "R10 second restart");
    @(negedge clk);
    free_ready = 1'b1;
    wait_free(nf + 1);
    chk("R7 free after reconfig", 64'(free_log[nf]), 64'({F_BASE, 3'd2, 9'h005}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec      = 0;
    n_bad      = 0;
    rst_n      = 1'b0;
    cfg_wr     = 1'b0;
    cfg_data   = '0;
    pull_valid = 1'b0;
    rd_ready   = 1'b1;
    free_ready = 1'b1;
    rsp_valid  = 1'b0;
    rsp_data   = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_small_size();
    t_basic();
    t_stall();
    t_overlap();
    t_spurious();
    t_recfg();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule